// File: doc/BRIEF.md
# Progressive-to-Interlaced Field Converter

This block sits in a streaming video path and turns progressive frames into interlaced fields. Every incoming frame is reduced to one half-height field: only the lines whose index parity matches the current field are forwarded. Lines of the other parity are taken from upstream and dropped. The field parity alternates from frame to frame. Pixels are treated as opaque 24-bit words, so any three-component format passes through untouched.

Both sides are valid-ready streams. The input carries a vsync flag on the first pixel of a frame and an hsync flag on the first pixel of each line. The output regenerates these flags for the field it produces. It also carries a field flag that stays constant for the whole field. The frame geometry (pixels per line, lines per frame) is supplied on run-time inputs. The internal pixel and line position is re-aligned by every sync, so a malformed frame is corrected at the next sync and does not drift.

Top module: `field_interlacer`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: A field with flag 0 forwards input lines 0, 2, 4, …. A field with flag 1 forwards lines 1, 3, 5, …. No pixel of any other line ever reaches the output.
- R3: out_field_o is 0 for the first frame after reset and toggles at each new input frame. It does not change between two output vsyncs.
- R4: out_vsync_o and out_hsync_o are both high on the first output pixel of a field. out_hsync_o alone is high on the first pixel of every later output line. Both are low on all other output pixels.
- R5: Forwarded pixel words leave bit-identical and in their input order.
- R6: While out_valid_o is high and out_ready_i is low, the output word and flags hold and in_ready_o is low.
- R7: Input accepted before the first vsync after reset is consumed and never output.
- R8: An input hsync restarts the pixel count and, if it arrives mid-line, advances the line. An input vsync restarts the line count. A short line or a short frame therefore re-aligns at the next sync.
- R9: Input lines with index at or above lines_per_frame_i are dropped.
- R10: Input pixel, vsync and hsync are ignored in any cycle where in_valid_i is low.
- R11: With out_ready_i held high, in_ready_o stays high and one input pixel is accepted per clock.
- R12: A line ends after pix_per_line_i pixels even without an hsync. The next pixel starts a new line and gets an output hsync when kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_per_line_i | input | DIM_W | Pixels per input line |
| lines_per_frame_i | input | DIM_W | Lines per input frame |
| in_pixel_i | input | PIX_W | Input pixel word |
| in_vsync_i | input | 1 | First pixel of a frame |
| in_hsync_i | input | 1 | First pixel of a line |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Block can take an input beat |
| out_pixel_o | output | PIX_W | Output pixel word |
| out_vsync_o | output | 1 | First pixel of an output field |
| out_hsync_o | output | 1 | First pixel of an output line |
| out_field_o | output | 1 | Field flag, 0 odd, 1 even |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream takes the output beat |

## Verification
The bench builds the block with the default widths (24-bit pixels, 16-bit geometry). It drives tiny run-time geometries: 6 pixels by 5 lines, then 4 by 4. Each field then lasts only a few dozen beats, and every frame-level corner can be reached in a few hundred cycles. These corners are the parity flip, a frame with too many lines, a short line, a short frame, a line wrap without hsync, and a geometry change between frames. Random input gaps carry bogus sync values. Random and mostly-low output ready patterns exercise the stall path against a scoreboard of expected field pixels.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int unsigned FI_PIX_W_DEF = 24;
  localparam int unsigned FI_DIM_W_DEF = 16;

  typedef enum logic {
    FIELD_ODD  = 1'b0,
    FIELD_EVEN = 1'b1
  } field_e;
endpackage

// File: rtl/fi_raster_track.sv
module fi_raster_track #(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic [DIM_W-1:0] ppl_i,
  output logic [DIM_W-1:0] col_o,
  output logic [DIM_W-1:0] row_o
);
  localparam logic [DIM_W-1:0] ONE = {{(DIM_W-1){1'b0}}, 1'b1};
  localparam logic [DIM_W-1:0] TOP = {DIM_W{1'b1}};

  logic [DIM_W-1:0] col_q, col_d;
  logic [DIM_W-1:0] row_q, row_d;
  logic [DIM_W-1:0] row_bump;
  logic [DIM_W-1:0] eff_col, eff_row, eff_row_bump;
  logic             line_end;

  always_comb begin
    row_bump = (row_q == TOP) ? row_q : row_q + ONE;
    if (vsync_i) begin
      eff_col = '0;
      eff_row = '0;
    end else if (hsync_i) begin
      eff_col = '0;
      eff_row = (col_q == '0) ? row_q : row_bump;
    end else begin
      eff_col = col_q;
      eff_row = row_q;
    end
    eff_row_bump = (eff_row == TOP) ? eff_row : eff_row + ONE;
    line_end     = (ppl_i <= ONE) || (eff_col >= ppl_i - ONE);
    col_d = col_q;
    row_d = row_q;
    if (fire_i) begin
      if (line_end) begin
        col_d = '0;
        row_d = eff_row_bump;
      end else begin
        col_d = eff_col + ONE;
        row_d = eff_row;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (fire_i) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign col_o = eff_col;
  assign row_o = eff_row;
endmodule

// File: rtl/fi_field_ctrl.sv
module fi_field_ctrl
  import fi_pkg::*;
#(
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             vsync_i,
  input  logic [DIM_W-1:0] col_i,
  input  logic [DIM_W-1:0] row_i,
  input  logic [DIM_W-1:0] lpf_i,
  output logic             keep_o,
  output logic             field_o,
  output logic             first_o,
  output logic             line_start_o
);
  field_e field_q, field_d;
  field_e upcoming_q, upcoming_d;
  logic   locked_q, locked_d;
  field_e cur_field;
  logic   active, parity_hit, in_frame;

  always_comb begin
    cur_field  = vsync_i ? upcoming_q : field_q;
    active     = vsync_i | locked_q;
    parity_hit = (row_i[0] == logic'(cur_field));
    in_frame   = (row_i < lpf_i);
    keep_o     = active & parity_hit & in_frame;
    line_start_o = (col_i == '0);
    first_o    = line_start_o && (row_i == {{(DIM_W-1){1'b0}}, logic'(cur_field)});
    field_o    = logic'(cur_field);

    field_d    = field_q;
    upcoming_d = upcoming_q;
    locked_d   = locked_q;
    if (fire_i && vsync_i) begin
      field_d    = upcoming_q;
      upcoming_d = (upcoming_q == FIELD_ODD) ? FIELD_EVEN : FIELD_ODD;
      locked_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q    <= FIELD_ODD;
      upcoming_q <= FIELD_ODD;
      locked_q   <= 1'b0;
    end else if (fire_i) begin
      field_q    <= field_d;
      upcoming_q <= upcoming_d;
      locked_q   <= locked_d;
    end
  end
endmodule

// File: rtl/fi_out_stage.sv
module fi_out_stage #(
  parameter int unsigned W = 27
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         out_ready_i,
  output logic         out_valid_o,
  output logic [W-1:0] word_o,
  output logic         take_ok_o
);
  logic         valid_q, valid_d;
  logic [W-1:0] word_q;

  always_comb begin
    take_ok_o = ~valid_q | out_ready_i;
    if (load_i)           valid_d = 1'b1;
    else if (out_ready_i) valid_d = 1'b0;
    else                  valid_d = valid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  assign out_valid_o = valid_q;
  assign word_o      = word_q;
endmodule

// File: rtl/field_interlacer.sv
module field_interlacer
  import fi_pkg::*;
#(
  parameter int unsigned PIX_W = FI_PIX_W_DEF,
  parameter int unsigned DIM_W = FI_DIM_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIM_W-1:0] pix_per_line_i,
  input  logic [DIM_W-1:0] lines_per_frame_i,
  input  logic [PIX_W-1:0] in_pixel_i,
  input  logic             in_vsync_i,
  input  logic             in_hsync_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic [PIX_W-1:0] out_pixel_o,
  output logic             out_vsync_o,
  output logic             out_hsync_o,
  output logic             out_field_o,
  output logic             out_valid_o,
  input  logic             out_ready_i
);
  localparam int unsigned WORD_W = PIX_W + 3;

  logic             in_fire;
  logic [DIM_W-1:0] col, row;
  logic             keep, field, first, line_start;
  logic [WORD_W-1:0] word_in, word_out;

  assign in_fire = in_valid_i & in_ready_o;

  fi_raster_track #(.DIM_W(DIM_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (in_fire),
    .vsync_i (in_vsync_i),
    .hsync_i (in_hsync_i),
    .ppl_i   (pix_per_line_i),
    .col_o   (col),
    .row_o   (row)
  );

  fi_field_ctrl #(.DIM_W(DIM_W)) u_field (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (in_fire),
    .vsync_i      (in_vsync_i),
    .col_i        (col),
    .row_i        (row),
    .lpf_i        (lines_per_frame_i),
    .keep_o       (keep),
    .field_o      (field),
    .first_o      (first),
    .line_start_o (line_start)
  );

  assign word_in = {in_pixel_i, first, line_start, field};

  fi_out_stage #(.W(WORD_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (in_fire & keep),
    .word_i      (word_in),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .word_o      (word_out),
    .take_ok_o   (in_ready_o)
  );

  assign out_pixel_o = word_out[WORD_W-1:3];
  assign out_vsync_o = word_out[2];
  assign out_hsync_o = word_out[1];
  assign out_field_o = word_out[0];
endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic [PIX_W-1:0] out_pixel_o,
  input logic             out_vsync_o,
  input logic             out_hsync_o,
  input logic             out_field_o,
  input logic             out_valid_o,
  input logic             out_ready_i
);
  logic seen_q, last_field_q, out_fire;
  assign out_fire = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q       <= 1'b0;
      last_field_q <= 1'b0;
    end else if (out_fire) begin
      seen_q       <= 1'b1;
      last_field_q <= out_field_o;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pixel_o) &&
    $stable(out_vsync_o) && $stable(out_hsync_o) && $stable(out_field_o)); // R6
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o); // R6
  AST_VSYNC_WITH_HSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_vsync_o |-> out_hsync_o); // R4
  AST_FIELD_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && seen_q && !out_vsync_o |-> out_field_o == last_field_q); // R3
  AST_FIRST_OUT_IS_VSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && !seen_q |-> out_vsync_o); // R7
endmodule

bind field_interlacer fi_checker #(.PIX_W(PIX_W)) u_fi_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_pixel_o (out_pixel_o),
  .out_vsync_o (out_vsync_o),
  .out_hsync_o (out_hsync_o),
  .out_field_o (out_field_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i)
);

// File: tb/tb_field_interlacer.sv
module tb_field_interlacer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  typedef struct packed {
    logic [23:0] d;
    logic vs, hs, fd;
  } exp_t;

  logic clk, rst_n;
  logic [15:0] ppl, lpf;
  logic [23:0] in_pixel;
  logic in_vsync, in_hsync, in_valid, in_ready;
  logic [23:0] out_pixel;
  logic out_vsync, out_hsync, out_field, out_valid, out_ready;

  field_interlacer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pix_per_line_i(ppl), .lines_per_frame_i(lpf),
    .in_pixel_i(in_pixel), .in_vsync_i(in_vsync), .in_hsync_i(in_hsync),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_pixel_o(out_pixel), .out_vsync_o(out_vsync), .out_hsync_o(out_hsync),
    .out_field_o(out_field), .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  exp_t q[$];
  int errors = 0, checks = 0, cyc = 0, fcount = 0;
  int rdy_mode = 0;
  bit gaps = 0, done = 0;
  logic [31:0] lfsr = 32'h1234_5679;

  initial clk = 0;
  always #HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // output ready pattern
  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= rnd() % 2 == 0;
      default: out_ready <= rnd() % 4 == 0;
    endcase
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(HALF - 1);
      if (rst_n && out_valid && !out_ready && checks < 5000)
        chk(!in_ready, "R6", "in_ready while stalled", int'(in_ready), 0);
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected output pixel", int'(out_pixel), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_pixel == e.d, "R5", "pixel word", int'(out_pixel), int'(e.d));
          chk(out_vsync == e.vs, "R4", "vsync", int'(out_vsync), int'(e.vs));
          chk(out_hsync == e.hs, "R4", "hsync", int'(out_hsync), int'(e.hs));
          chk(out_field == e.fd, "R3", "field flag", int'(out_field), int'(e.fd));
        end
      end
    end
  end

  // one input beat; called right after a negedge
  task automatic send_px(input logic [23:0] d, input logic vs, input logic hs);
    bit ok;
    if (gaps && rnd() % 3 == 0) begin
      in_valid = 0; in_pixel = rnd(); in_vsync = 1; in_hsync = 1; // R10 bogus
      @(negedge clk);
    end
    in_pixel = d; in_vsync = vs; in_hsync = hs; in_valid = 1;
    forever begin
      #(HALF - 1);
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
  endtask

  task automatic idle();
    in_valid = 0; in_vsync = 0; in_hsync = 0;
  endtask

  // frame driver with expected-field model
  task automatic send_frame(input int lines, input int short_line,
                            input int short_len, input bit use_hs);
    int field = fcount % 2;
    bit first = 1;
    for (int l = 0; l < lines; l++) begin
      int len = (l == short_line) ? short_len : int'(ppl);
      for (int p = 0; p < len; p++) begin
        logic [23:0] d = {fcount[7:0], l[7:0], p[7:0]};
        if (l < int'(lpf) && (l % 2) == field) begin
          exp_t e;
          e.d = d; e.vs = first; e.hs = (p == 0); e.fd = field[0];
          q.push_back(e);
          first = 0;
        end
        send_px(d, l == 0 && p == 0, p == 0 && (use_hs || l == 0));
      end
    end
    idle();
    fcount++;
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(q.size() == 0, req, "pending expected pixels", q.size(), 0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int c0, rdy_lows;
    rst_n = 0; ppl = 16'd6; lpf = 16'd5;
    in_pixel = 0; idle(); out_ready = 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R7: junk before the first vsync, with hsync on some beats
    for (int i = 0; i < 7; i++) send_px(24'hABC000 + 24'(i), 0, i == 0);
    idle();
    repeat (4) begin
      @(negedge clk); #(HALF - 1);
      chk(out_valid == 0, "R7", "output before first vsync", int'(out_valid), 0);
    end
    @(negedge clk);

    // F0 field 0, full rate: R2, R11
    rdy_mode = 0; gaps = 0;
    rdy_lows = 0;
    fork
      begin : watch_rdy
        forever begin @(negedge clk); #(HALF - 1); if (!in_ready) rdy_lows++; end
      end
    join_none
    c0 = cyc;
    send_frame(5, -1, 0, 1);
    disable watch_rdy;
    chk(cyc - c0 == 30, "R11", "cycles for 30 pixels", cyc - c0, 30);
    chk(rdy_lows == 0, "R11", "in_ready low cycles", rdy_lows, 0);
    drain("R2");

    // F1 field 1, seven lines against lpf 5: R9, random ready and gaps (R10)
    rdy_mode = 1; gaps = 1;
    send_frame(7, -1, 0, 1);
    drain("R9");

    // F2 field 0 with a short line 2: R8
    send_frame(5, 2, 3, 1);
    drain("R8");

    // F3 field 1, short frame of 3 lines: R8
    send_frame(3, -1, 0, 1);
    drain("R8");

    // F4 field 0 with new geometry and no hsync after line 0: R12
    ppl = 16'd4; lpf = 16'd4;
    send_frame(4, -1, 0, 0);
    drain("R12");

    // F5 field 1 under heavy stall: R6, R3
    rdy_mode = 2;
    send_frame(4, -1, 0, 1);
    drain("R6");

    // F6 field 0 again: R3 toggle back
    rdy_mode = 1; gaps = 0;
    send_frame(4, -1, 0, 1);
    drain("R3");

    done = 1;
    summary();
    $finish;
  end
endmodule